// File: doc/BRIEF.md
# Legacy I/O Configuration Register Unit

This block holds the configuration state of a small legacy I/O controller with one printer port and two serial ports. The host reaches the block through a simple I/O bus with an address, write data, read data and separate read and write strobes. Two fixed byte addresses serve as the block's interface. The lower address selects a register number, and the upper address moves data into or out of the selected register.

Configuration access is locked after reset. The host unlocks it by writing a key byte to the index address. It then programs each device's base address and power enable bit, and writes a second key to lock the unit again.

For each device the block reports an active flag. A device is active only when its power bit is set and its programmed base lies at or above 0x100. The block also decodes a chip-select for each device. The chip-select is high while the bus address falls inside that device's window. The window starts at the device's base and is 4 bytes wide for the printer port and 8 bytes wide for each serial port.

Top module: `iocfg_unit`

## Requirements
- R1: A write of 0x55 to the index address 0x2E puts the unit into configuration mode.
- R2: In configuration mode, a write of 0xAA to address 0x2E leaves configuration mode. The selected register number is kept.
- R3: In configuration mode, a write of any other value to 0x2E selects that register number. A read of 0x2E returns the selected number while in configuration mode and 0xFF otherwise.
- R4: In configuration mode, reads and writes at the data address 0x2F reach the selected register. All 8 bits of registers 0x01, 0x02, 0x23, 0x24 and 0x25 are stored, so a write that changes one power bit leaves the other bits as written.
- R5: Outside configuration mode, data-address writes are ignored and data-address reads return 0xFF. Index writes other than 0x55 do not change the selected register number.
- R6: An unimplemented register number reads 0x00, and writes to it change no implemented register.
- R7: Each device has an active flag and a base register holding I/O address bits [9:2]. The printer port is active when bit 2 of register 0x01 is set and register 0x23 is at least 0x40 (base 0x100 or above). Serial port 1 is active when bit 3 of register 0x02 is set and register 0x24 is at least 0x40. Serial port 2 is active when bit 7 of register 0x02 is set and register 0x25 is at least 0x40.
- R8: The printer port chip-select is high only when that port is active and the full 16-bit bus address lies within base to base+3, where base is register 0x23 times 4.
- R9: Each serial port chip-select is high only when that port is active and the full 16-bit bus address lies within base to base+7.
- R10: After reset, every register and the selected register number are 0. The unit is locked, and no device is active or selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busAddr | input | 16 | Host I/O address |
| busWrData | input | 8 | Host write data |
| busWr | input | 1 | Write strobe, one cycle per write |
| busRd | input | 1 | Read strobe |
| busRdData | output | 8 | Read data for the index and data addresses (combinational), 0x00 elsewhere |
| ppSel | output | 1 | Printer port chip-select |
| sp1Sel | output | 1 | Serial port 1 chip-select |
| sp2Sel | output | 1 | Serial port 2 chip-select |
| ppActive | output | 1 | Printer port active flag |
| sp1Active | output | 1 | Serial port 1 active flag |
| sp2Active | output | 1 | Serial port 2 active flag |

## Verification
The access sequences check several things:
- Locked and unlocked accesses are interleaved, so a missing lock check shows up as a changed register value or a non-0xFF read.
- An unimplemented register number is read and written, which shows whether a write leaks into a real register.
- A power register is rewritten with one bit cleared, which separates full storage from bit-wise handling.

The device-level cases cover the address boundaries:
- A base register is set to 0x3F and then to 0x40, which tells the below-0x100 rule apart from the power-bit rule.
- Chip-selects are probed at the first and last address of each window and one past each end. A probe with a high address bit set catches a decoder that ignores the upper address bits.

// File: rtl/iocfg_pkg.sv
package iocfg_pkg;

  localparam int NUM_DEV = 3;
  localparam int DEV_PP  = 0;
  localparam int DEV_SP1 = 1;
  localparam int DEV_SP2 = 2;

  // Register numbers reached through the data address
  localparam logic [7:0] PWR_IDX  [2]       = '{8'h01, 8'h02};
  localparam logic [7:0] BASE_IDX [NUM_DEV] = '{8'h23, 8'h24, 8'h25};

  // Which power register and which bit enables each device
  localparam int PWR_SLOT [NUM_DEV] = '{0, 1, 1};
  localparam int PWR_BIT  [NUM_DEV] = '{2, 3, 7};

  // Decode window in bytes per device
  localparam int WIN_BYTES [NUM_DEV] = '{4, 8, 8};

  // Lowest base address at which a device may be active
  localparam int MIN_BASE_ADDR = 'h100;
  localparam logic [7:0] MIN_BASE_REG = 8'(MIN_BASE_ADDR >> 2);

  typedef struct packed {
    logic       regWr;   // write the selected register this cycle
    logic [7:0] regIdx;  // currently selected register number
    logic [7:0] wrData;  // data for the write
  } cfgStrobe_t;

endpackage

// File: rtl/iocfg_ctrl.sv
module iocfg_ctrl
  import iocfg_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] IDX_PORT  = 'h2E,
  parameter logic [ADDR_W-1:0] DATA_PORT = 'h2F,
  parameter logic [7:0] KEY_ENTER = 8'h55,
  parameter logic [7:0] KEY_EXIT  = 8'hAA
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [7:0]        busWrData,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [7:0]        regRdVal,
  output cfgStrobe_t        stb,
  output logic [7:0]        busRdData
);

  logic       cfgQ;
  logic [7:0] idxQ;
  logic       idxHit, dataHit;

  assign idxHit  = (busAddr == IDX_PORT);
  assign dataHit = (busAddr == DATA_PORT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ <= 1'b0;
      idxQ <= 8'h00;
    end else if (busWr && idxHit) begin
      if (busWrData == KEY_ENTER) begin
        cfgQ <= 1'b1;
      end else if (cfgQ) begin
        if (busWrData == KEY_EXIT) cfgQ <= 1'b0;
        else                       idxQ <= busWrData;
      end
    end
  end

  always_comb begin
    stb.regWr  = busWr && dataHit && cfgQ;
    stb.regIdx = idxQ;
    stb.wrData = busWrData;
  end

  always_comb begin
    busRdData = 8'h00;
    if (busRd && idxHit)       busRdData = cfgQ ? idxQ : 8'hFF;
    else if (busRd && dataHit) busRdData = cfgQ ? regRdVal : 8'hFF;
  end

  a_r1_enter_key: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && idxHit && busWrData == KEY_ENTER) |=> cfgQ);

  a_r2_exit_key: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && idxHit && busWrData == KEY_EXIT && cfgQ) |=> (!cfgQ && $stable(idxQ)));

  a_r5_locked_index: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgQ) |=> $stable(idxQ));

  a_r5_locked_no_write: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgQ && !(busWr && idxHit)) |=> !cfgQ);

endmodule

// File: rtl/iocfg_regs.sv
module iocfg_regs
  import iocfg_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  cfgStrobe_t         stb,
  input  logic [ADDR_W-1:0]  busAddr,
  output logic [7:0]         regRdVal,
  output logic [NUM_DEV-1:0] devActive,
  output logic [NUM_DEV-1:0] devSel
);

  localparam int PAD_W = ADDR_W - 10;

  logic [7:0] pwrQ  [2];
  logic [7:0] baseQ [NUM_DEV];

  for (genvar p = 0; p < 2; p++) begin : g_pwr
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                   pwrQ[p] <= 8'h00;
      else if (stb.regWr && stb.regIdx == PWR_IDX[p]) pwrQ[p] <= stb.wrData;
    end
  end

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
    logic [ADDR_W-1:0] baseAddr;
    logic [ADDR_W-1:0] offset;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                        baseQ[d] <= 8'h00;
      else if (stb.regWr && stb.regIdx == BASE_IDX[d]) baseQ[d] <= stb.wrData;
    end

    assign baseAddr     = {{PAD_W{1'b0}}, baseQ[d], 2'b00};
    assign offset       = busAddr - baseAddr;
    assign devActive[d] = pwrQ[PWR_SLOT[d]][PWR_BIT[d]] && (baseQ[d] >= MIN_BASE_REG);
    assign devSel[d]    = devActive[d] && (offset < ADDR_W'(WIN_BYTES[d]));

    a_r9_sel_needs_active: assert property (@(posedge clk) disable iff (!rstN)
      devSel[d] |-> devActive[d]);

    a_r4_base_store: assert property (@(posedge clk) disable iff (!rstN)
      (stb.regWr && stb.regIdx == BASE_IDX[d]) |=> (baseQ[d] == $past(stb.wrData)));
  end

  always_comb begin
    regRdVal = 8'h00;
    for (int p = 0; p < 2; p++)
      if (stb.regIdx == PWR_IDX[p]) regRdVal = pwrQ[p];
    for (int d = 0; d < NUM_DEV; d++)
      if (stb.regIdx == BASE_IDX[d]) regRdVal = baseQ[d];
  end

  logic idxKnown;
  always_comb begin
    idxKnown = 1'b0;
    for (int p = 0; p < 2; p++)       if (stb.regIdx == PWR_IDX[p])  idxKnown = 1'b1;
    for (int d = 0; d < NUM_DEV; d++) if (stb.regIdx == BASE_IDX[d]) idxKnown = 1'b1;
  end

  a_r6_unimpl_write: assert property (@(posedge clk) disable iff (!rstN)
    (stb.regWr && !idxKnown) |=> ($stable(pwrQ[0]) && $stable(pwrQ[1]) &&
      $stable(baseQ[0]) && $stable(baseQ[1]) && $stable(baseQ[2])));

  a_r7_power_store: assert property (@(posedge clk) disable iff (!rstN)
    (stb.regWr && stb.regIdx == PWR_IDX[1]) |=> (pwrQ[1] == $past(stb.wrData)));

endmodule

// File: rtl/iocfg_unit.sv
module iocfg_unit
  import iocfg_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [7:0]        busWrData,
  input  logic              busWr,
  input  logic              busRd,
  output logic [7:0]        busRdData,
  output logic              ppSel,
  output logic              sp1Sel,
  output logic              sp2Sel,
  output logic              ppActive,
  output logic              sp1Active,
  output logic              sp2Active
);

  cfgStrobe_t         stb;
  logic [7:0]         regRdVal;
  logic [NUM_DEV-1:0] devActive, devSel;

  iocfg_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrData(busWrData),
    .busWr(busWr), .busRd(busRd), .regRdVal(regRdVal), .stb(stb),
    .busRdData(busRdData)
  );

  iocfg_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rstN(rstN), .stb(stb), .busAddr(busAddr),
    .regRdVal(regRdVal), .devActive(devActive), .devSel(devSel)
  );

  assign ppSel     = devSel[DEV_PP];
  assign sp1Sel    = devSel[DEV_SP1];
  assign sp2Sel    = devSel[DEV_SP2];
  assign ppActive  = devActive[DEV_PP];
  assign sp1Active = devActive[DEV_SP1];
  assign sp2Active = devActive[DEV_SP2];

  a_r10_reset_idle: assert property (@(posedge clk) $rose(rstN) |-> (devActive == '0));

endmodule

// File: tb/sim_iocfg_unit.sv
module sim_iocfg_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] busAddr = 16'h0;
  logic [7:0]  busWrData = 8'h0;
  logic        busWr = 1'b0;
  logic        busRd = 1'b0;
  logic [7:0]  busRdData;
  logic        ppSel, sp1Sel, sp2Sel, ppActive, sp1Active, sp2Active;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  iocfg_unit u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrData(busWrData),
    .busWr(busWr), .busRd(busRd), .busRdData(busRdData),
    .ppSel(ppSel), .sp1Sel(sp1Sel), .sp2Sel(sp2Sel),
    .ppActive(ppActive), .sp1Active(sp1Active), .sp2Active(sp2Active)
  );

  // {isRead, addrLow, data-or-expected}
  localparam int NV = 25;
  localparam logic [16:0] VEC [NV] = '{
    {1'b1, 8'h2F, 8'hFF},  // R5 locked data read
    {1'b1, 8'h2E, 8'hFF},  // R3 locked index read
    {1'b0, 8'h2F, 8'h12},  // R5 locked data write, ignored
    {1'b0, 8'h2E, 8'h23},  // R5 locked index write, ignored
    {1'b0, 8'h2E, 8'h55},  // R1 enter
    {1'b1, 8'h2E, 8'h00},  // R5 index unchanged while locked
    {1'b0, 8'h2E, 8'h23},  // R3 select
    {1'b1, 8'h2F, 8'h00},  // R5 earlier write lost
    {1'b0, 8'h2F, 8'hFE},
    {1'b1, 8'h2F, 8'hFE},  // R4
    {1'b1, 8'h2E, 8'h23},  // R3
    {1'b0, 8'h2E, 8'h30},
    {1'b0, 8'h2F, 8'h77},
    {1'b1, 8'h2F, 8'h00},  // R6
    {1'b0, 8'h2E, 8'h02},
    {1'b0, 8'h2F, 8'h88},
    {1'b1, 8'h2F, 8'h88},  // R4
    {1'b0, 8'h2F, 8'h80},
    {1'b1, 8'h2F, 8'h80},  // R4 other bit kept
    {1'b0, 8'h2E, 8'hAA},  // R2 exit
    {1'b1, 8'h2F, 8'hFF},  // R2/R5
    {1'b0, 8'h2F, 8'h00},  // R5 ignored
    {1'b0, 8'h2E, 8'h55},
    {1'b1, 8'h2E, 8'h02},  // R2 index kept
    {1'b1, 8'h2F, 8'h80}   // R5 write had no effect
  };

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic busRead(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    busAddr = a; busRd = 1'b1;
    #1 d = busRdData;
    @(negedge clk);
    busRd = 1'b0;
  endtask

  task automatic probe(input logic [15:0] a, input logic [2:0] expSel, input string tag);
    @(negedge clk);
    busAddr = a;
    #1 check({5'b0, ppSel, sp1Sel, sp2Sel}, {5'b0, expSel}, tag);
  endtask

  task automatic cfgWrite(input logic [7:0] idx, input logic [7:0] d);
    busWrite(16'h2E, idx);
    busWrite(16'h2F, d);
  endtask

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    check({5'b0, ppActive, sp1Active, sp2Active}, 8'h00, "R10 active after reset");
    check({5'b0, ppSel, sp1Sel, sp2Sel}, 8'h00, "R10 select after reset");
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][16]) begin
        busRead({8'h00, VEC[i][15:8]}, rd);
        check(rd, VEC[i][7:0], $sformatf("R4/R5 vector %0d", i));
      end else begin
        busWrite({8'h00, VEC[i][15:8]}, VEC[i][7:0]);
      end
    end

    // Now unlocked; reg23=FE (0x3F8), reg02=0x80
    check({5'b0, ppActive, sp1Active, sp2Active}, 8'h00, "R7 no power bits");
    cfgWrite(8'h01, 8'h04);
    @(negedge clk);
    check({7'b0, ppActive}, 8'h01, "R7 pp active");
    probe(16'h03F8, 3'b100, "R8 pp first");
    probe(16'h03FB, 3'b100, "R8 pp last");
    probe(16'h03FC, 3'b000, "R8 pp past end");
    probe(16'h03F7, 3'b000, "R8 pp before");
    probe(16'h13F8, 3'b000, "R8 pp high bit");

    cfgWrite(8'h02, 8'h88);
    cfgWrite(8'h24, 8'h3F);
    @(negedge clk);
    check({7'b0, sp1Active}, 8'h00, "R7 sp1 base 0xFC");
    cfgWrite(8'h24, 8'h40);
    @(negedge clk);
    check({7'b0, sp1Active}, 8'h01, "R7 sp1 base 0x100");
    probe(16'h0100, 3'b010, "R9 sp1 first");
    probe(16'h0107, 3'b010, "R9 sp1 last");
    probe(16'h0108, 3'b000, "R9 sp1 past end");

    cfgWrite(8'h25, 8'hBE);
    @(negedge clk);
    check({7'b0, sp2Active}, 8'h01, "R7 sp2 active");
    probe(16'h02FF, 3'b001, "R9 sp2 last");
    probe(16'h0300, 3'b000, "R9 sp2 past end");
    probe(16'h02F7, 3'b000, "R9 sp2 before");

    cfgWrite(8'h02, 8'h08);
    @(negedge clk);
    check({5'b0, ppActive, sp1Active, sp2Active}, 8'h06, "R7 sp2 power off");
    cfgWrite(8'h01, 8'h00);
    probe(16'h03F8, 3'b000, "R8 pp power off");

    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check({5'b0, ppActive, sp1Active, sp2Active}, 8'h00, "R10 active after second reset");
    rstN = 1'b1;
    busRead(16'h2F, rd);
    check(rd, 8'hFF, "R10 locked after reset");
    busWrite(16'h2E, 8'h55);
    busRead(16'h2E, rd);
    check(rd, 8'h00, "R10 index cleared");
    busWrite(16'h2E, 8'h24);
    busRead(16'h2F, rd);
    check(rd, 8'h00, "R10 base cleared");

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

endmodule